// File: doc/BRIEF.md
# Half-to-Double Precision Widener

This block turns a 16-bit binary16 floating-point code into the exact 64-bit binary64 code that has the same value. No information is lost. Every finite half value, both infinities and every NaN payload can be represented in the wider format. The conversion uses only field extraction, a leading-zero count, shifts and small integer adds. It contains no floating-point arithmetic unit.

A producer presents one code per cycle on `in_half` and qualifies it with `in_valid`. After a fixed number of clock cycles, set by the `LATENCY` parameter, the widened code appears on `out_double` with `out_valid` high. Results leave in the same order the inputs arrived, and a new input may be accepted on every cycle. The input is sorted into five classes: zero, subnormal, normal, infinity and NaN. Each class has its own assembly rule. A half subnormal is renormalised into a double normal in a single combinational step: the leading-zero count of its fraction sets both the left shift and the exponent adjustment.

Top module: `h2d_widener`

## Requirements
- R1: Input layout is sign at bit 15, a 5-bit exponent with bias 15 at bits 14:10, and a 10-bit fraction at bits 9:0. Output layout is sign at bit 63, an 11-bit exponent with bias 1023 at bits 62:52, and a 52-bit fraction at bits 51:0.
- R2: `out_valid` rises exactly `LATENCY` cycles (default 2) after the clock edge that samples `in_valid` high. It is low in every other cycle.
- R3: While `rst` is high at a clock edge, `out_valid` is low after that edge, and inputs that were in flight are discarded.
- R4: An input with exponent 0 and fraction 0 produces a double with exponent 0 and fraction 0, and keeps the sign.
- R5: An input with exponent 0 and a nonzero fraction whose highest set bit is at position k (0..9) produces a double with biased exponent 999+k. The fraction bits below position k are moved so that bit k-1 lands at output bit 51. All lower output fraction bits are zero.
- R6: An input with exponent 31 and fraction 0 produces a double with exponent 2047 and fraction 0 (a signed infinity).
- R7: An input with exponent 31 and a nonzero fraction produces a double with exponent 2047 and input fraction bits 9:0 placed at output bits 51:42. The quiet bit stays in the top fraction position, and output bits 41:0 are zero.
- R8: An input with exponent e in 1..30 produces a double with biased exponent e+1008 and input fraction bits 9:0 at output bits 51:42, with zeros below.
- R9: Output bit 63 always equals input bit 15, in every class.
- R10: Inputs presented on consecutive cycles are all converted and delivered in arrival order, with no gaps added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_half` in this cycle |
| in_half | input | 16 | binary16 code to widen |
| out_valid | output | 1 | Qualifies `out_double` |
| out_double | output | 64 | binary64 code of the same value |

## Verification
The assertions place no restriction on the input code: every 16-bit pattern is a legal input, including all subnormals and NaN payloads. They do assume that `in_valid` is a known level at every clock edge and that `rst` is high from time zero. The stimulus drives `in_valid` to 0 or 1 on every cycle, holds reset at start-up and during a mid-stream reset, and covers the whole code space with a back-to-back sweep. It then adds random codes with random idle gaps.

// File: rtl/h2d_pkg.sv
package h2d_pkg;

  typedef enum logic [2:0] {
    HC_ZERO,
    HC_SUB,
    HC_NORM,
    HC_INF,
    HC_NAN
  } hclass_t;

  function automatic int bias_of(input int exp_w);
    return (1 << (exp_w - 1)) - 1;
  endfunction

endpackage

// File: rtl/h2d_classify.sv
module h2d_classify
  import h2d_pkg::*;
#(
  parameter int SE = 5,
  parameter int SF = 10,
  localparam int SW = 1 + SE + SF
) (
  input  logic [SW-1:0] code,
  output logic          sign,
  output logic [SE-1:0] exp_f,
  output logic [SF-1:0] frac_f,
  output hclass_t       cls
);

  logic exp_zero;
  logic exp_ones;
  logic frac_zero;

  assign sign   = code[SW-1];
  assign exp_f  = code[SW-2 -: SE];
  assign frac_f = code[SF-1:0];

  assign exp_zero  = (exp_f == '0);
  assign exp_ones  = (exp_f == '1);
  assign frac_zero = (frac_f == '0);

  always_comb begin
    if (exp_zero)      cls = frac_zero ? HC_ZERO : HC_SUB;
    else if (exp_ones) cls = frac_zero ? HC_INF : HC_NAN;
    else               cls = HC_NORM;
  end

endmodule

// File: rtl/h2d_lzc.sv
module h2d_lzc #(
  parameter int W = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);

  logic hit;

  always_comb begin
    cnt = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (vec[i]) hit = 1'b1;
        else        cnt = cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/h2d_assemble.sv
module h2d_assemble
  import h2d_pkg::*;
#(
  parameter int SE = 5,
  parameter int SF = 10,
  parameter int DE = 11,
  parameter int DF = 52,
  localparam int CW = $clog2(SF + 1),
  localparam int DW = 1 + DE + DF,
  localparam int PAD = DF - SF,
  localparam int BIAS_DIFF = bias_of(DE) - bias_of(SE)
) (
  input  hclass_t       cls,
  input  logic          sign,
  input  logic [SE-1:0] exp_f,
  input  logic [SF-1:0] frac_f,
  input  logic [CW-1:0] lz,
  output logic [DW-1:0] dbl
);

  logic [CW-1:0] sh;
  logic [SF-1:0] norm_frac;
  logic [DE-1:0] sub_exp;
  logic [DE-1:0] nrm_exp;
  logic [DE-1:0] o_exp;
  logic [SF-1:0] o_top;

  // one extra step past the leading zeros pushes the hidden one out
  assign sh        = lz + CW'(1);
  assign norm_frac = frac_f << sh;
  assign sub_exp   = DE'(BIAS_DIFF) - DE'(lz);
  assign nrm_exp   = DE'(exp_f) + DE'(BIAS_DIFF);

  always_comb begin
    unique case (cls)
      HC_ZERO: begin o_exp = '0;      o_top = '0;        end
      HC_SUB:  begin o_exp = sub_exp; o_top = norm_frac; end
      HC_INF:  begin o_exp = '1;      o_top = '0;        end
      HC_NAN:  begin o_exp = '1;      o_top = frac_f;    end
      default: begin o_exp = nrm_exp; o_top = frac_f;    end
    endcase
  end

  assign dbl = {sign, o_exp, o_top, {PAD{1'b0}}};

endmodule

// File: rtl/h2d_pipe.sv
module h2d_pipe #(
  parameter int W = 64,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_v,
  input  logic [W-1:0] in_d,
  output logic         out_v,
  output logic [W-1:0] out_d
);

  logic [DEPTH-1:0] v_q;
  logic [W-1:0]     d_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) v_q[0] <= 1'b0;
    else     v_q[0] <= in_v;
    d_q[0] <= in_d;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) v_q[s] <= 1'b0;
      else     v_q[s] <= v_q[s-1];
      d_q[s] <= d_q[s-1];
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_d = d_q[DEPTH-1];

endmodule

// File: rtl/h2d_widener.sv
module h2d_widener
  import h2d_pkg::*;
#(
  parameter int SE = 5,
  parameter int SF = 10,
  parameter int DE = 11,
  parameter int DF = 52,
  parameter int LATENCY = 2,
  localparam int SW = 1 + SE + SF,
  localparam int DW = 1 + DE + DF,
  localparam int CW = $clog2(SF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [SW-1:0] in_half,
  output logic          out_valid,
  output logic [DW-1:0] out_double
);

  logic          f_sign;
  logic [SE-1:0] f_exp;
  logic [SF-1:0] f_frac;
  hclass_t       f_cls;
  logic [CW-1:0] f_lz;
  logic [DW-1:0] f_dbl;

  h2d_classify #(.SE(SE), .SF(SF)) u_cls (
    .code   (in_half),
    .sign   (f_sign),
    .exp_f  (f_exp),
    .frac_f (f_frac),
    .cls    (f_cls)
  );

  h2d_lzc #(.W(SF)) u_lzc (
    .vec (f_frac),
    .cnt (f_lz)
  );

  h2d_assemble #(.SE(SE), .SF(SF), .DE(DE), .DF(DF)) u_asm (
    .cls    (f_cls),
    .sign   (f_sign),
    .exp_f  (f_exp),
    .frac_f (f_frac),
    .lz     (f_lz),
    .dbl    (f_dbl)
  );

  h2d_pipe #(.W(DW), .DEPTH(LATENCY)) u_pipe (
    .clk   (clk),
    .rst   (rst),
    .in_v  (in_valid),
    .in_d  (f_dbl),
    .out_v (out_valid),
    .out_d (out_double)
  );

endmodule

// File: rtl/h2d_widener_chk.sv
module h2d_widener_chk
  import h2d_pkg::*;
#(
  parameter int SE = 5,
  parameter int SF = 10,
  parameter int DE = 11,
  parameter int DF = 52,
  parameter int LATENCY = 2,
  localparam int SW = 1 + SE + SF,
  localparam int DW = 1 + DE + DF,
  localparam int PAD = DF - SF,
  localparam int BIAS_DIFF = bias_of(DE) - bias_of(SE)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [SW-1:0] in_half,
  input logic          out_valid,
  input logic [DW-1:0] out_double
);

  logic [LATENCY-1:0] v_sh;
  logic [SW-1:0]      c_sh [LATENCY];

  always_ff @(posedge clk) begin
    if (rst) v_sh <= '0;
    else begin
      v_sh[0] <= in_valid;
      for (int i = 1; i < LATENCY; i++) v_sh[i] <= v_sh[i-1];
    end
    c_sh[0] <= in_half;
    for (int i = 1; i < LATENCY; i++) c_sh[i] <= c_sh[i-1];
  end

  logic [SW-1:0] src;
  logic [SE-1:0] s_exp;
  logic [SF-1:0] s_frac;
  logic [DE-1:0] o_exp;
  logic [DF-1:0] o_frac;

  assign src    = c_sh[LATENCY-1];
  assign s_exp  = src[SW-2 -: SE];
  assign s_frac = src[SF-1:0];
  assign o_exp  = out_double[DW-2 -: DE];
  assign o_frac = out_double[DF-1:0];

  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sh[LATENCY-1]);

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_exp == '0 && s_frac == '0) |-> (out_double[DW-2:0] == '0));

  assert_sub_range_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_exp == '0 && s_frac != '0) |->
      (o_exp <= DE'(BIAS_DIFF) && o_exp >= DE'(BIAS_DIFF - SF + 1) && o_frac[PAD-1:0] == '0));

  assert_inf_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_exp == '1 && s_frac == '0) |-> (o_exp == '1 && o_frac == '0));

  assert_nan_payload_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_exp == '1 && s_frac != '0) |-> (o_exp == '1 && o_frac == {s_frac, {PAD{1'b0}}}));

  assert_normal_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && s_exp != '0 && s_exp != '1) |->
      (o_exp == DE'(s_exp) + DE'(BIAS_DIFF) && o_frac == {s_frac, {PAD{1'b0}}}));

  assert_sign_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_double[DW-1] == src[SW-1]));

endmodule

bind h2d_widener h2d_widener_chk #(
  .SE(SE), .SF(SF), .DE(DE), .DF(DF), .LATENCY(LATENCY)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_half    (in_half),
  .out_valid  (out_valid),
  .out_double (out_double)
);

// File: tb/h2d_widener_tb.sv
`timescale 1ns/1ps
module h2d_widener_tb;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic [63:0] out_double;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  logic [15:0] q_code [$];
  int          q_cyc  [$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc++;

  h2d_widener #(.LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_half(in_half),
    .out_valid(out_valid), .out_double(out_double)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference built from the field rules of R1, R4..R8
  function automatic logic [63:0] ref_widen(input logic [15:0] h);
    logic [4:0]  e;
    logic [9:0]  f;
    logic [10:0] m;
    int          ue;
    e = h[14:10];
    f = h[9:0];
    if (e == 0 && f == 0) return {h[15], 63'd0};
    if (e == 0) begin
      ue = -14;
      m = {1'b0, f};
      do begin
        m = m << 1;
        ue--;
      end while (!m[10]);
      return {h[15], 11'(ue + 1023), m[9:0], 42'd0};
    end
    if (e == 5'd31) return {h[15], 11'h7ff, f, 42'd0};
    return {h[15], 11'(int'(e) - 15 + 1023), f, 42'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (h[14:10] == 0)  return (h[9:0] == 0) ? "R4 zero" : "R5 subnormal";
    if (h[14:10] == 31) return (h[9:0] == 0) ? "R6 infinity" : "R7 nan";
    return "R8 normal";
  endfunction

  // monitor: outputs are read away from the active edge
  always @(negedge clk) begin
    if (mon_en && !rst) begin
      if (out_valid) begin
        if (q_code.size() == 0) begin
          check(1'b0, "R2 spurious out_valid", 64'(out_valid), 64'd0);
        end else begin
          logic [15:0] c;
          int          t;
          logic [63:0] e;
          c = q_code.pop_front();
          t = q_cyc.pop_front();
          e = ref_widen(c);
          check(cyc == t + LAT, "R2 R10 latency/order", 64'(cyc), 64'(t + LAT));
          check(out_double == e, tag_of(c), out_double, e);
          check(out_double[63] == c[15], "R9 sign", 64'(out_double[63]), 64'(c[15]));
        end
      end else if (q_cyc.size() != 0 && q_cyc[0] + LAT < cyc) begin
        check(1'b0, "R2 missing out_valid", 64'(out_valid), 64'd1);
        void'(q_code.pop_front());
        void'(q_cyc.pop_front());
      end
    end
  end

  task automatic drive(input bit v, input logic [15:0] c);
    @(negedge clk);
    in_valid = v;
    in_half  = c;
    if (v) begin
      q_code.push_back(c);
      q_cyc.push_back(cyc);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst = 1'b1;
    in_valid = 1'b0;
    q_code.delete();
    q_cyc.delete();
    @(negedge clk);
    check(out_valid == 1'b0, "R3 reset clears", 64'(out_valid), 64'd0);
    @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
  endtask

  initial begin
    logic [15:0] corners [14];
    void'($urandom(32'd4242));
    corners = '{16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h03ff, 16'h0200,
                16'h7c00, 16'hfc00, 16'h7c01, 16'h7e00, 16'hfdff, 16'h0400,
                16'h7bff, 16'h3c00};
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R3 reset state", 64'(out_valid), 64'd0);
    rst = 1'b0;
    mon_en = 1'b1;
    // R1 R10: every code, back to back
    for (int i = 0; i < 65536; i++) drive(1'b1, 16'(i));
    drive(1'b0, '0);
    // directed corner codes
    foreach (corners[i]) drive(1'b1, corners[i]);
    drive(1'b0, '0);
    // random codes with random idle gaps
    for (int i = 0; i < 3000; i++) drive(($urandom % 4) != 0, 16'($urandom));
    // reset while results are in flight
    drive(1'b1, 16'h0001);
    drive(1'b1, 16'h7e00);
    do_reset();
    check(out_valid == 1'b0, "R3 in-flight discarded", 64'(out_valid), 64'd0);
    for (int i = 0; i < 200; i++) drive(($urandom % 2) != 0, 16'($urandom));
    drive(1'b0, '0);
    repeat (LAT + 3) @(negedge clk);
    check(q_code.size() == 0, "R2 all delivered", 64'(q_code.size()), 64'd0);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule